// File: doc/BRIEF.md
# Dataflow Grid Instruction Placement Unit

This unit assigns each decoded instruction a cell in a two-dimensional array of ALUs. Data moves from north to south. It accepts at most one instruction per cycle. Each instruction names a destination register, up to two source registers, an operation kind and a latency in sub-cycle delay units. One cycle after it accepts an instruction, the unit reports where that instruction sits: the column, the row, a memory sequence number for loads and stores, and an estimated completion time.

Each register has its own column. The unit keeps three kinds of state:
- per register: the row just below its latest producer, the row just below the latest consumer of its current value, and the time that value is ready;
- the row just below the most recent conditional branch;
- a counter for memory operations.

The chosen row is the smallest one that meets every constraint. When no legal row is left, the unit raises a sticky full flag, and the frontend stops issuing. A flush empties all tracking state so that a new configuration can begin.

Top module: `grid_placer`

## Requirements
- R1: After reset or flush, full and out_valid are low. The first independent instruction lands in row 0, and its completion time equals its latency.
- R2: The reported column equals the destination register for kinds ALU (0) and load (1). It is 0 for kinds store (2) and conditional branch (3), which write no register.
- R3: The row is strictly greater than the row of the most recent placed write to every used, non-zero source register.
- R4: For ALU and load, the row is strictly greater than the destination column's previous write row. It is also strictly greater than every row that has read that column's current value.
- R5: Every instruction, of any kind, is placed strictly below the most recent placed conditional branch.
- R6: Loads and stores raise out_mem and receive sequence numbers 0, 1, 2, … in program order. ALU and branch instructions do not advance the count.
- R7: The completion time is the largest ready time among the used, non-zero sources, plus the latency. Unused sources and register 0 contribute 0.
- R8: An ALU or load with destination register 0 gives no placement and changes no state. Register 0 as a source imposes no constraint.
- R9: If the required row is at least NROWS, full rises in the next cycle with no placement. From then on, full stays high and out_valid stays low, whatever is issued, until a flush.
- R10: Flush clears all state in one cycle and takes priority over an instruction presented in the same cycle.
- R11: All outputs are registered. The result for an instruction accepted at edge k appears after edge k. Back-to-back dependent instructions see each other's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears all tracking state |
| in_valid | input | 1 | Instruction present |
| in_kind | input | 2 | 0 ALU, 1 load, 2 store, 3 conditional branch |
| in_dst | input | RIDX_W | Destination register |
| in_src_a | input | RIDX_W | First source register |
| in_use_a | input | 1 | First source is used |
| in_src_b | input | RIDX_W | Second source register |
| in_use_b | input | 1 | Second source is used |
| in_lat | input | LAT_W | Latency in sub-cycle units |
| out_valid | output | 1 | A placement is reported |
| out_col | output | RIDX_W | Column of the placed instruction |
| out_row | output | ROWI_W | Row of the placed instruction |
| out_mem | output | 1 | Instruction is a load or store |
| out_seq | output | SEQ_W | Memory sequence number |
| out_time | output | TIME_W | Estimated completion time |
| full | output | 1 | No legal row remained; sticky until flush |

## Verification
The assertions assume that completion times never wrap within TIME_W between flushes. The bench meets this by keeping latencies below 8 and by flushing whenever the array fills, so a dependency chain cannot exceed NROWS rows. The assertions also assume the inputs are stable across each sampling edge. The bench drives every input on the falling edge only. The random phase limits registers to the range 0 to 7 so that source and destination collisions occur often, and register 0 is included as both a source and a destination.

// File: rtl/grid_placer_pkg.sv
package grid_placer_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_LOAD   = 2'd1,
    K_STORE  = 2'd2,
    K_BRANCH = 2'd3
  } op_kind_t;
endpackage

// File: rtl/gp_reg_track.sv
// Per-register tables: first free row after the last write, first free row
// after the last read of the current value, and the value's ready time.
module gp_reg_track #(
  parameter int NREGS  = 32,
  parameter int RIDX_W = 5,
  parameter int ROW_W  = 6,
  parameter int TIME_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [RIDX_W-1:0] a_idx,
  input  logic              a_use,
  input  logic [RIDX_W-1:0] b_idx,
  input  logic              b_use,
  input  logic [RIDX_W-1:0] d_idx,
  input  logic              upd_en,
  input  logic              upd_write,
  input  logic [ROW_W-1:0]  row_next,
  input  logic [TIME_W-1:0] upd_time,
  output logic [ROW_W-1:0]  a_minw,
  output logic [ROW_W-1:0]  b_minw,
  output logic [ROW_W-1:0]  d_minw,
  output logic [ROW_W-1:0]  d_minr,
  output logic [TIME_W-1:0] a_rdy,
  output logic [TIME_W-1:0] b_rdy
);
  logic [ROW_W-1:0]  minw_q [NREGS];
  logic [ROW_W-1:0]  minr_q [NREGS];
  logic [TIME_W-1:0] rdy_q  [NREGS];

  logic a_live, b_live;
  assign a_live = a_use && (a_idx != '0);
  assign b_live = b_use && (b_idx != '0);

  always_comb begin
    a_minw = a_live ? minw_q[a_idx] : '0;
    b_minw = b_live ? minw_q[b_idx] : '0;
    a_rdy  = a_live ? rdy_q[a_idx]  : '0;
    b_rdy  = b_live ? rdy_q[b_idx]  : '0;
    d_minw = (d_idx != '0) ? minw_q[d_idx] : '0;
    d_minr = (d_idx != '0) ? minr_q[d_idx] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int r = 0; r < NREGS; r++) begin
        minw_q[r] <= '0;
        minr_q[r] <= '0;
        rdy_q[r]  <= '0;
      end
    end else if (upd_en) begin
      for (int r = 1; r < NREGS; r++) begin
        if (upd_write && (d_idx == RIDX_W'(r))) begin
          minw_q[r] <= row_next;
          minr_q[r] <= row_next;
          rdy_q[r]  <= upd_time;
        end else if ((a_live && a_idx == RIDX_W'(r)) ||
                     (b_live && b_idx == RIDX_W'(r))) begin
          if (row_next > minr_q[r]) minr_q[r] <= row_next;
        end
      end
    end
  end

  // R3: after a committed write, the destination's producer bound is nonzero
  p_write_seen_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_write && d_idx != '0 && !clr) |=> (d_minw == $past(row_next)) || (d_idx != $past(d_idx)));
endmodule

// File: rtl/gp_row_select.sv
// Combinational row and completion-time selection.
module gp_row_select #(
  parameter int NROWS  = 32,
  parameter int ROW_W  = 6,
  parameter int TIME_W = 12,
  parameter int LAT_W  = 4
) (
  input  logic [ROW_W-1:0]  a_minw,
  input  logic [ROW_W-1:0]  b_minw,
  input  logic [ROW_W-1:0]  d_minw,
  input  logic [ROW_W-1:0]  d_minr,
  input  logic [ROW_W-1:0]  br_min,
  input  logic              is_write,
  input  logic [TIME_W-1:0] a_rdy,
  input  logic [TIME_W-1:0] b_rdy,
  input  logic [LAT_W-1:0]  lat,
  output logic [ROW_W-1:0]  row_need,
  output logic              fits,
  output logic [TIME_W-1:0] done_time
);
  localparam int NC = 5;
  logic [ROW_W-1:0] cand [NC];
  logic [ROW_W-1:0] stage [NC];

  assign cand[0] = a_minw;
  assign cand[1] = b_minw;
  assign cand[2] = br_min;
  assign cand[3] = is_write ? d_minw : '0;
  assign cand[4] = is_write ? d_minr : '0;

  assign stage[0] = cand[0];
  for (genvar i = 1; i < NC; i++) begin : g_max
    assign stage[i] = (cand[i] > stage[i-1]) ? cand[i] : stage[i-1];
  end

  assign row_need = stage[NC-1];
  assign fits     = (row_need < ROW_W'(NROWS));

  logic [TIME_W-1:0] base;
  assign base      = (a_rdy > b_rdy) ? a_rdy : b_rdy;
  assign done_time = base + TIME_W'(lat);
endmodule

// File: rtl/gp_mem_seq.sv
// Program-order sequence counter for loads and stores.
module gp_mem_seq #(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [SEQ_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // R6: each memory operation advances the count by exactly one
  p_seq_step_r6: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> cnt == $past(cnt) + 1'b1);
  p_seq_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/grid_placer.sv
module grid_placer #(
  parameter int NREGS  = 32,
  parameter int NROWS  = 32,
  parameter int LAT_W  = 4,
  parameter int TIME_W = 12,
  parameter int SEQ_W  = 8,
  localparam int RIDX_W = $clog2(NREGS),
  localparam int ROWI_W = $clog2(NROWS),
  localparam int ROW_W  = $clog2(NROWS) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic [RIDX_W-1:0] in_dst,
  input  logic [RIDX_W-1:0] in_src_a,
  input  logic              in_use_a,
  input  logic [RIDX_W-1:0] in_src_b,
  input  logic              in_use_b,
  input  logic [LAT_W-1:0]  in_lat,
  output logic              out_valid,
  output logic [RIDX_W-1:0] out_col,
  output logic [ROWI_W-1:0] out_row,
  output logic              out_mem,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [TIME_W-1:0] out_time,
  output logic              full
);
  import grid_placer_pkg::*;

  op_kind_t kind;
  assign kind = op_kind_t'(in_kind);

  logic is_write, is_mem, is_branch, dropped, accept, commit, overflow;
  assign is_write  = (kind == K_ALU) || (kind == K_LOAD);
  assign is_mem    = (kind == K_LOAD) || (kind == K_STORE);
  assign is_branch = (kind == K_BRANCH);
  assign dropped   = is_write && (in_dst == '0);
  assign accept    = in_valid && !full && !flush;

  logic [ROW_W-1:0]  a_minw, b_minw, d_minw, d_minr, row_need, row_next;
  logic [TIME_W-1:0] a_rdy, b_rdy, done_time;
  logic              fits;
  logic [ROW_W-1:0]  br_q;
  logic [SEQ_W-1:0]  seq_cnt;

  assign commit   = accept && !dropped && fits;
  assign overflow = accept && !dropped && !fits;
  assign row_next = row_need + 1'b1;

  gp_reg_track #(
    .NREGS(NREGS), .RIDX_W(RIDX_W), .ROW_W(ROW_W), .TIME_W(TIME_W)
  ) u_track (
    .clk(clk), .rst(rst), .clr(flush),
    .a_idx(in_src_a), .a_use(in_use_a),
    .b_idx(in_src_b), .b_use(in_use_b),
    .d_idx(in_dst),
    .upd_en(commit), .upd_write(is_write),
    .row_next(row_next), .upd_time(done_time),
    .a_minw(a_minw), .b_minw(b_minw),
    .d_minw(d_minw), .d_minr(d_minr),
    .a_rdy(a_rdy), .b_rdy(b_rdy)
  );

  gp_row_select #(
    .NROWS(NROWS), .ROW_W(ROW_W), .TIME_W(TIME_W), .LAT_W(LAT_W)
  ) u_sel (
    .a_minw(a_minw), .b_minw(b_minw),
    .d_minw(d_minw), .d_minr(d_minr),
    .br_min(br_q), .is_write(is_write),
    .a_rdy(a_rdy), .b_rdy(b_rdy), .lat(in_lat),
    .row_need(row_need), .fits(fits), .done_time(done_time)
  );

  gp_mem_seq #(.SEQ_W(SEQ_W)) u_seq (
    .clk(clk), .rst(rst), .clr(flush),
    .inc(commit && is_mem), .cnt(seq_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || flush)               br_q <= '0;
    else if (commit && is_branch)   br_q <= row_next;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_valid <= 1'b0;
      out_col   <= '0;
      out_row   <= '0;
      out_mem   <= 1'b0;
      out_seq   <= '0;
      out_time  <= '0;
      full      <= 1'b0;
    end else begin
      out_valid <= commit;
      if (commit) begin
        out_col  <= is_write ? in_dst : '0;
        out_row  <= row_need[ROWI_W-1:0];
        out_mem  <= is_mem;
        out_seq  <= seq_cnt;
        out_time <= done_time;
      end
      if (overflow) full <= 1'b1;
    end
  end

  // R10: the cycle after a flush shows an empty, non-full unit
  p_flush_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (!full && !out_valid));
  // R9: full is sticky until flush
  p_full_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (full && !flush) |=> full);
  // R9: nothing is placed while full
  p_full_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    full |-> !out_valid);
  // R8: a writing instruction never lands in column 0
  p_col_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(in_kind) == 2'd0 || $past(in_kind) == 2'd1)) |-> out_col != '0);
  // R7: completion never precedes the instruction's own latency
  p_time_floor_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_time >= TIME_W'($past(in_lat)));
  // R5: a branch placement raises the branch bound past its row
  p_branch_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (commit && is_branch) |=> br_q > ROW_W'(out_row));
endmodule

// File: tb/grid_placer_bench.sv
module grid_placer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32;
  localparam int NRG = 32;

  logic clk = 1'b0;
  logic rst, flush, in_valid, in_use_a, in_use_b;
  logic [1:0]  in_kind;
  logic [4:0]  in_dst, in_src_a, in_src_b, out_col;
  logic [3:0]  in_lat;
  logic        out_valid, out_mem, full;
  logic [4:0]  out_row;
  logic [7:0]  out_seq;
  logic [11:0] out_time;

  always #(CLK_PERIOD/2) clk = ~clk;

  grid_placer u_grid_placer (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_kind(in_kind), .in_dst(in_dst), .in_src_a(in_src_a),
    .in_use_a(in_use_a), .in_src_b(in_src_b), .in_use_b(in_use_b),
    .in_lat(in_lat), .out_valid(out_valid), .out_col(out_col),
    .out_row(out_row), .out_mem(out_mem), .out_seq(out_seq),
    .out_time(out_time), .full(full)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural model state
  int mw[NRG], mr[NRG], rdy[NRG];
  int br, seq;
  bit efull, evalid, emem;
  int ecol, erow, eseq, etime;
  string etag;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(etag, "full", int'(full), int'(efull));
    chk(etag, "valid", int'(out_valid), int'(evalid));
    if (evalid && out_valid) begin
      chk(etag, "col", int'(out_col), ecol);
      chk(etag, "row", int'(out_row), erow);
      chk(etag, "mem", int'(out_mem), int'(emem));
      chk(etag, "time", int'(out_time), etime);
      if (emem) chk(etag, "seq", int'(out_seq), eseq);
    end
  endtask

  function automatic void model_clear();
    for (int r = 0; r < NRG; r++) begin mw[r] = 0; mr[r] = 0; rdy[r] = 0; end
    br = 0; seq = 0; efull = 0; evalid = 0;
  endfunction

  function automatic void model(bit v, bit fl, int k, int d, int a, bit ua, int b, bit ub, int lat);
    bit wr, la, lb;
    int rn, t;
    evalid = 0;
    if (fl) begin model_clear(); return; end
    if (!v || efull) return;
    wr = (k == 0 || k == 1);
    if (wr && d == 0) return;
    la = ua && a != 0; lb = ub && b != 0;
    rn = br;
    if (la && mw[a] > rn) rn = mw[a];
    if (lb && mw[b] > rn) rn = mw[b];
    if (wr && mw[d] > rn) rn = mw[d];
    if (wr && mr[d] > rn) rn = mr[d];
    t = 0;
    if (la && rdy[a] > t) t = rdy[a];
    if (lb && rdy[b] > t) t = rdy[b];
    t = t + lat;
    if (rn >= NR) begin efull = 1; return; end
    evalid = 1; erow = rn; ecol = wr ? d : 0; etime = t;
    emem = (k == 1 || k == 2); eseq = seq % 256;
    if (emem) seq++;
    if (la && rn + 1 > mr[a]) mr[a] = rn + 1;
    if (lb && rn + 1 > mr[b]) mr[b] = rn + 1;
    if (wr) begin mw[d] = rn + 1; mr[d] = rn + 1; rdy[d] = t; end
    if (k == 3) br = rn + 1;
  endfunction

  task automatic step(input bit v, input bit fl, input int k, input int d,
                      input int a, input bit ua, input int b, input bit ub,
                      input int lat, input string tag);
    @(negedge clk);
    compare();
    flush = fl; in_valid = v; in_kind = 2'(k); in_dst = 5'(d);
    in_src_a = 5'(a); in_use_a = ua; in_src_b = 5'(b); in_use_b = ub;
    in_lat = 4'(lat);
    model(v, fl, k, d, a, ua, b, ub, lat);
    etag = tag;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; flush = 0; in_valid = 0; in_kind = 0; in_dst = 0;
    in_src_a = 0; in_src_b = 0; in_use_a = 0; in_use_b = 0; in_lat = 0;
    model_clear(); etag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    idle("R1");
    // R1: first independent instruction at row 0, time = latency
    step(1, 0, 0, 1, 0, 0, 0, 0, 3, "R1");
    // R3 / R11: back-to-back dependents
    step(1, 0, 0, 2, 1, 1, 0, 0, 2, "R3");
    step(1, 0, 0, 3, 1, 1, 2, 1, 1, "R3");
    // R4: rewrite r1 must sit below its readers
    step(1, 0, 0, 1, 0, 1, 0, 0, 1, "R4");
    step(1, 0, 0, 3, 7, 0, 0, 0, 2, "R4");
    // R6 / R2: load and store
    step(1, 0, 1, 4, 2, 1, 0, 0, 5, "R6");
    step(1, 0, 2, 9, 4, 1, 3, 1, 1, "R2");
    step(1, 0, 0, 5, 0, 0, 0, 0, 1, "R6");
    step(1, 0, 1, 6, 0, 0, 0, 0, 2, "R6");
    // R5: branch then independent instructions of each kind
    step(1, 0, 3, 7, 3, 1, 0, 0, 1, "R5");
    step(1, 0, 0, 8, 0, 0, 0, 0, 1, "R5");
    step(1, 0, 2, 0, 0, 0, 0, 0, 1, "R5");
    // R8: write to r0 dropped, r0 source unconstrained
    step(1, 0, 0, 0, 1, 1, 0, 0, 4, "R8");
    step(1, 0, 1, 0, 1, 1, 0, 0, 4, "R8");
    step(1, 0, 0, 10, 0, 1, 0, 1, 2, "R8");
    // R7: unused source flags ignore named registers
    step(1, 0, 0, 11, 4, 0, 3, 1, 3, "R7");
    step(1, 0, 0, 12, 4, 1, 3, 0, 0, "R7");
    // R10: flush wins over a same-cycle instruction
    step(1, 1, 0, 1, 0, 0, 0, 0, 1, "R10");
    step(1, 0, 1, 2, 0, 0, 0, 0, 6, "R10");
    step(1, 0, 0, 3, 2, 1, 0, 0, 1, "R1");
    // R9: chain fills the array
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < NR + 1; i++) step(1, 0, 0, 1, 1, 1, 0, 0, 1, "R9");
    step(1, 0, 0, 5, 0, 0, 0, 0, 1, "R9");
    step(1, 0, 1, 6, 0, 0, 0, 0, 1, "R9");
    idle("R9");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 0, 0, 5, 0, 0, 0, 0, 1, "R10");
    // mixed stream
    for (int i = 0; i < 400; i++) begin
      if (efull) step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R10");
      else step(1, 0, int'($urandom_range(3)), int'($urandom_range(7)),
                int'($urandom_range(7)), 1'($urandom_range(1)),
                int'($urandom_range(7)), 1'($urandom_range(1)),
                int'($urandom_range(7)), "R3 mix");
    end
    idle("R11");
    @(negedge clk);
    compare();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule